// File: doc/BRIEF.md
# Data-Driven Channel Readout Serializer

This block reads out a many-channel front end without a buffer. It counts a fixed serial frame on the fast readout clock. At each frame boundary it picks the next channel whose enable flag is set, working round-robin onward from the last channel it served. It names that channel to the converter for the coming sample period. When the conversion result comes back a fixed number of frames later, the block joins it with the channel number, hit flag, rise time and time stamp captured at selection. It then shifts the 34-bit word out MSB first.

Each frame is exactly one converter sample period long, so readout runs in lockstep with sampling. Valid words can follow one another with no idle clock, and frames in which no channel was enabled carry a low data-valid and an all-zero line. A downstream acquisition system only has to watch `frame_start` and `data_valid`.

Top module: `readout_serializer`

## Requirements
- R1: A frame lasts FW = 34 clocks. `frame_start` is high in the first clock of every frame and low in the other 33. `adc_go` and `adc_chan` stay constant within a frame.
- R2: The word is sent MSB first on `ser_data`, with bit 33 in the `frame_start` clock. The layout is: bit 33 hit flag, bits 32:26 channel number, bits 25:19 rise time, bits 18:12 time stamp, bits 11:0 converter result.
- R3: `data_valid` is high in all 34 clocks of a frame that carries a serviced channel. It is low in all 34 clocks of a frame that carries none, and `ser_data` is 0 throughout such a frame.
- R4: Only a channel whose `ch_en` bit is 1 in the last clock of the previous frame is selected. When no bit is set, `adc_go` is low for that frame.
- R5: The search starts at the channel after the last one serviced and wraps from NCH-1 to 0. A frame without a selection leaves the search position unchanged. With all channels enabled, the channels are served in ascending order.
- R6: The word sent in frame k describes the channel selected for frame k-LAT (LAT = 2 by default). Its converter field is `adc_data` as sampled in the last clock of frame k-1.
- R7: During and directly after reset, `data_valid`, `ser_data` and `adc_go` are 0 and `frame_start` is 1. The first search starts at channel 0, and the first LAT frames are empty.
- R8: The hit flag, rise time and time stamp in a word are the values present for that channel in the clock in which it was selected. Later changes to these inputs do not alter the word.
- R9: Consecutive valid frames are sent back to back, with `data_valid` high across the frame boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_en | input | NCH | Per-channel readout enable |
| ch_hit | input | NCH | Per-channel above-threshold flag |
| rise_time | input | NCH*RTW | Packed per-channel rise-time values |
| time_stamp | input | NCH*TSW | Packed per-channel time-stamp values |
| adc_data | input | ADCW | Converter result, sampled at the last clock of a frame |
| adc_go | output | 1 | A channel is selected for conversion this frame |
| adc_chan | output | CHW | Channel selected for conversion this frame |
| ser_data | output | 1 | Serial word, MSB first |
| data_valid | output | 1 | High across frames that carry a channel |
| frame_start | output | 1 | First clock of each frame |

## Verification
The scan is driven with no channel enabled, a single channel, a sparse set that spans the wrap from the top channel to channel 0, and every channel enabled for more than one full sweep. These patterns separate a stuck search pointer, a missing wrap and a search that restarts from channel 0. Each frame's selection is compared with an arithmetic round-robin model, and the whole 34-bit word is rebuilt from the serial line and compared field by field against values computed from the channel number. A hit flag that is toggled on every frame after selection exposes metadata captured at the wrong cycle. The drain back to no enabled channels shows the LAT-frame delay and the empty frames.

// File: rtl/readout_serializer.sv
module readout_serializer #(
  parameter int NCH  = 100,
  parameter int CHW  = 7,
  parameter int RTW  = 7,
  parameter int TSW  = 7,
  parameter int ADCW = 12,
  parameter int LAT  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NCH-1:0]      ch_en,
  input  logic [NCH-1:0]      ch_hit,
  input  logic [NCH*RTW-1:0]  rise_time,
  input  logic [NCH*TSW-1:0]  time_stamp,
  input  logic [ADCW-1:0]     adc_data,
  output logic                adc_go,
  output logic [CHW-1:0]      adc_chan,
  output logic                ser_data,
  output logic                data_valid,
  output logic                frame_start
);
  localparam int FW = 1 + CHW + RTW + TSW + ADCW;
  localparam int CW = $clog2(FW);
  localparam int MW = 2 + CHW + RTW + TSW;

  logic [CW-1:0]  cnt;
  logic [CHW-1:0] ptr, pick;
  logic           found, dv;
  logic [FW-1:0]  sreg;
  logic [MW-1:0]  dly [LAT];
  logic [MW-1:0]  cap;
  logic [MW-1:0]  oldest;

  wire last = (cnt == CW'(FW - 1));

  always_comb begin
    int idx;
    found = 1'b0;
    pick  = ptr;
    for (int off = 1; off <= NCH; off++) begin
      idx = int'(ptr) + off;
      if (idx >= NCH) idx = idx - NCH;
      if (!found && ch_en[idx]) begin
        found = 1'b1;
        pick  = CHW'(idx);
      end
    end
  end

  assign cap = {found, ch_hit[pick], pick,
                rise_time[int'(pick)*RTW +: RTW],
                time_stamp[int'(pick)*TSW +: TSW]};
  assign oldest = dly[LAT-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      ptr    <= CHW'(NCH - 1);
      adc_go <= 1'b0;
      adc_chan <= '0;
      sreg   <= '0;
      dv     <= 1'b0;
      for (int i = 0; i < LAT; i++) dly[i] <= '0;
    end else if (last) begin
      cnt      <= '0;
      ptr      <= found ? pick : ptr;
      adc_go   <= found;
      adc_chan <= pick;
      dly[0]   <= cap;
      for (int i = 1; i < LAT; i++) dly[i] <= dly[i-1];
      dv   <= oldest[MW-1];
      sreg <= oldest[MW-1] ? {oldest[MW-2:0], adc_data} : '0;
    end else begin
      cnt  <= cnt + 1'b1;
      sreg <= sreg << 1;
    end
  end

  assign ser_data    = sreg[FW-1];
  assign data_valid  = dv;
  assign frame_start = (cnt == '0);
endmodule

// File: rtl/readout_serializer_chk.sv
module readout_serializer_chk #(
  parameter int NCH = 100,
  parameter int CHW = 7
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] ch_en,
  input logic           adc_go,
  input logic [CHW-1:0] adc_chan,
  input logic           ser_data,
  input logic           data_valid,
  input logic           frame_start
);
  p_frame_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);

  p_sel_steady_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |-> ($stable(adc_go) && $stable(adc_chan)));

  p_dv_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |-> $stable(data_valid));

  p_quiet_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !data_valid |-> !ser_data);

  p_enabled_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && adc_go) |-> ((($past(ch_en) >> adc_chan) & 1) != 0));

  p_idle_none_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && ($past(ch_en) == '0)) |-> !adc_go);

  p_chan_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    adc_go |-> (int'(adc_chan) < NCH));
endmodule

bind readout_serializer readout_serializer_chk #(.NCH(NCH), .CHW(CHW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .adc_go(adc_go),
  .adc_chan(adc_chan), .ser_data(ser_data), .data_valid(data_valid),
  .frame_start(frame_start));

// File: tb/sim_readout_serializer.sv
module sim_readout_serializer;
  localparam int NCH = 100, CHW = 7, RTW = 7, TSW = 7, ADCW = 12, LAT = 2;
  localparam int FW = 1 + CHW + RTW + TSW + ADCW;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  logic [NCH-1:0] ch_en, ch_hit;
  logic [NCH*RTW-1:0] rise_time;
  logic [NCH*TSW-1:0] time_stamp;
  logic [ADCW-1:0] adc_data;
  logic adc_go, ser_data, data_valid, frame_start;
  logic [CHW-1:0] adc_chan;

  readout_serializer u0 (.*);

  int checks = 0, fails = 0;
  int mptr = NCH - 1;
  int fr = 0;
  bit hv [0:1023];
  int hch [0:1023];
  bit hhit [0:1023];

  function automatic int rt_of(int c);  return (c * 5 + 1) % 128;     endfunction
  function automatic int ts_of(int c);  return (c * 11 + 3) % 128;    endfunction
  function automatic int adc_of(int c); return (c * 37 + 1445) % 4096; endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic one_frame(string req, bit first);
    bit efound;
    int ech, src;
    logic [FW-1:0] w, ew;
    bit ev, dvbad, fsbad;
    if (!first) @(negedge clk);
    chk(frame_start == 1'b1, "R1", "frame_start at frame begin", frame_start, 1);
    efound = 0;
    ech = mptr;
    if (fr > 0)
      for (int off = 1; off <= NCH; off++)
        if (!efound && ch_en[(mptr + off) % NCH]) begin
          efound = 1;
          ech = (mptr + off) % NCH;
        end
    chk(adc_go == efound, req, "adc_go (R4)", adc_go, efound);
    if (efound) begin
      chk(int'(adc_chan) == ech, req, "adc_chan (R5)", adc_chan, ech);
      mptr = ech;
    end
    hv[fr] = efound;
    hch[fr] = ech;
    hhit[fr] = efound ? ch_hit[ech] : 1'b0;
    src = fr - (LAT - 1);
    adc_data = (src >= 0 && hv[src]) ? ADCW'(adc_of(hch[src])) : '1;
    src = fr - LAT;
    ev = (src >= 0) && hv[src];
    ew = '0;
    if (ev) ew = {hhit[src], CHW'(hch[src]), RTW'(rt_of(hch[src])),
                  TSW'(ts_of(hch[src])), ADCW'(adc_of(hch[src]))};
    w[FW-1] = ser_data;
    dvbad = (data_valid != ev);
    fsbad = 0;
    for (int b = FW - 2; b >= 0; b--) begin
      @(negedge clk);
      w[b] = ser_data;
      if (data_valid != ev) dvbad = 1;
      if (frame_start) fsbad = 1;
    end
    chk(!fsbad, "R1", "frame_start inside frame", fsbad, 0);
    chk(!dvbad, ev ? "R3/R9" : "R3", "data_valid over frame", ev ? 0 : 1, ev);
    chk(w == ew, ev ? "R2/R6/R8" : "R3", "serial word", w, ew);
    fr++;
  endtask

  initial begin
    #200000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual hang expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 0;
    ch_en = '0;
    ch_hit = '0;
    adc_data = '0;
    for (int c = 0; c < NCH; c++) begin
      rise_time[c*RTW +: RTW] = RTW'(rt_of(c));
      time_stamp[c*TSW +: TSW] = TSW'(ts_of(c));
    end
    repeat (3) @(negedge clk);
    // R7: reset state
    chk(data_valid == 0, "R7", "data_valid in reset", data_valid, 0);
    chk(ser_data == 0, "R7", "ser_data in reset", ser_data, 0);
    chk(adc_go == 0, "R7", "adc_go in reset", adc_go, 0);
    chk(frame_start == 1, "R7", "frame_start in reset", frame_start, 1);
    rst_n = 1;
    one_frame("R7", 1);
    // R4: nothing enabled
    for (int i = 0; i < 3; i++) one_frame("R4", 0);
    // R4/R8: a single channel
    ch_en[5] = 1; ch_hit[5] = 1;
    for (int i = 0; i < 4; i++) one_frame("R4", 0);
    // R5: sparse set across the wrap
    ch_en = '0; ch_hit = '0;
    ch_en[0] = 1; ch_en[1] = 1; ch_en[50] = 1; ch_en[99] = 1;
    ch_hit[1] = 1; ch_hit[99] = 1;
    for (int i = 0; i < 10; i++) one_frame("R5", 0);
    // R9: all enabled, back to back
    ch_en = '1;
    for (int c = 0; c < NCH; c++) ch_hit[c] = (c % 3 == 0);
    for (int i = 0; i < 105; i++) one_frame("R9", 0);
    // R8: hit toggled every frame after selection
    ch_en = '0; ch_en[7] = 1;
    for (int i = 0; i < 6; i++) begin
      ch_hit[7] = ~ch_hit[7];
      one_frame("R8", 0);
    end
    // R6/R3: drain to empty frames
    ch_en = '0;
    for (int i = 0; i < 4; i++) one_frame("R6", 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule